// File: doc/BRIEF.md
# Configuration Command Register Sequencer

This block holds the current five-bit configuration command and converts it into the controls that drive a configuration engine. A command runs when it is written. It runs again every time the frame address is reloaded, so an engine that streams many frames repeats its setup command at each new address without software writing it again. The block produces two kinds of output. Single-cycle strobes drive the CRC engine, the flip-flop restore, the watchdog, warm boot, bulk RAM clear, clock switch and readback-CRC recompute. Sticky state covers the data-path mode, the interconnect hold, word alignment, capture edge and a one-time flash re-read latch.

Start-up and shutdown do not take effect when their commands run. A start-up command arms a request. The request fires only after both a passing CRC check and a desynchronise command have occurred. A shutdown command arms a request that fires on the next passing CRC check or the next CRC-reset command. The start-up and shutdown phase machines are outside this block, as are the CRC engine and the flash and clock logic. The block only emits their request and trigger signals.

Top module: `cfg_cmd_seq`

## Requirements
- R1: On reset `cmd_q_o` is 00000. A cycle with `cmd_we` high loads `cmd_wdata` into `cmd_q_o`, which is visible after that clock edge.
- R2: A command executes in any cycle where `cmd_we` or `far_load` is high. The code executed is `cmd_wdata` when `cmd_we` is high and otherwise the held `cmd_q_o`. Every result of an execution appears after the clock edge that ends the executing cycle. The following codes each give a one-cycle pulse: 00111 on `crc_rst_o`, 01010 on `ff_restore_o`, 10001 on `wdog_reload_o`, 01111 on `warm_boot_o`, 00110 on `ram_clear_o` and 01001 on `clk_switch_o`.
- R3: Code 00001 sets `mode_o` to 1 (write), 00010 sets it to 2 (multi-frame write) and 00100 sets it to 3 (read). Any other listed code except 00000 sets `mode_o` to 0. Otherwise `mode_o` holds.
- R4: Code 01000 drives `ic_hold_n_o` low and code 00011 drives it high. The signal holds between these commands and is high after reset.
- R5: `rb_crc_o` pulses for one cycle when code 10000 executes. It also pulses when code 00011 executes while `ic_hold_n_o` is low.
- R6: Code 00101 sets `startup_pend_o` and discards earlier events. In a later cycle, once a `crc_ok` pulse and an execution of code 01101 have both been seen, `startup_go_o` pulses for one cycle and `startup_pend_o` clears.
- R7: Code 01011 sets `shutdown_pend_o`. In a later cycle, a `crc_ok` pulse or an execution of code 00111 gives a one-cycle `shutdown_go_o` pulse and clears the pending flag.
- R8: `aligned_o` is set by `sync_found` and cleared by code 01101, and the clear wins. `cfg_word_accept` equals `cfg_word_valid` AND `aligned_o`, so words are ignored while `aligned_o` is low.
- R9: Code 10010 pulses `flash_reread_o` once. Later executions of 10010 produce no pulse. An execution while `fallback` is high produces no pulse and does not use up the single pulse.
- R10: Code 10011 sets `neg_edge_o`, and only reset clears it.
- R11: Code 00000 and the unlisted codes (01100, 01110, 10100 to 11111) change no output other than `cmd_q_o`.
- R12: After reset all pulses and pending flags are 0, `mode_o` is 0, `aligned_o` is 0, `neg_edge_o` is 0 and `ic_hold_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 5 | Command code to write |
| far_load | input | 1 | Frame address reloaded, re-executes held command |
| crc_ok | input | 1 | CRC check passed pulse |
| sync_found | input | 1 | Sync word detected, sets alignment |
| fallback | input | 1 | Fallback has occurred (level) |
| cfg_word_valid | input | 1 | Configuration data word present |
| cfg_word_accept | output | 1 | Data word accepted (aligned) |
| cmd_q_o | output | 5 | Held command code |
| mode_o | output | 2 | Data-path mode: 0 idle, 1 write, 2 multi-frame, 3 read |
| crc_rst_o | output | 1 | CRC reset strobe |
| ff_restore_o | output | 1 | Flip-flop restore strobe |
| wdog_reload_o | output | 1 | Watchdog reload strobe |
| warm_boot_o | output | 1 | Warm boot strobe |
| ram_clear_o | output | 1 | Bulk RAM clear strobe |
| clk_switch_o | output | 1 | Clock frequency switch strobe |
| rb_crc_o | output | 1 | Readback CRC recompute strobe |
| flash_reread_o | output | 1 | Restart bitstream read at address 0 |
| ic_hold_n_o | output | 1 | Interconnect hold, active low |
| aligned_o | output | 1 | Word alignment flag |
| neg_edge_o | output | 1 | Falling-edge capture select |
| startup_pend_o | output | 1 | Start-up request armed |
| startup_go_o | output | 1 | Start-up trigger pulse |
| shutdown_pend_o | output | 1 | Shutdown request armed |
| shutdown_go_o | output | 1 | Shutdown trigger pulse |

## Verification
The hardest state to reach is a completed start-up. It needs an armed request, then a CRC pass and a desynchronise command, with no frame-address reload in between that re-runs the start-up code and discards the events already seen. Directed sequences arm the request and deliver the two events in both orders. Random write, reload and CRC traffic then hits the re-arming and same-cycle cases. An interconnect-hold toggle driven from a reload is covered in the same way. Every cycle is compared against a bench model of the command semantics.

// File: rtl/cfg_cmd_pkg.sv
// Shared definitions for the configuration command sequencer.
// Assumes a five-bit command code; code values are decoded externally
// by software writing the register, so they are fixed.
package cfg_cmd_pkg;

    localparam int CMD_W  = 5;
    localparam int MODE_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP        = 5'b00000,
        CMD_WRITE      = 5'b00001,
        CMD_MULTI      = 5'b00010,
        CMD_HOLD_REL   = 5'b00011,
        CMD_READ       = 5'b00100,
        CMD_START      = 5'b00101,
        CMD_RAM_CLR    = 5'b00110,
        CMD_CRC_RST    = 5'b00111,
        CMD_HOLD_SET   = 5'b01000,
        CMD_CLK_SW     = 5'b01001,
        CMD_FF_REST    = 5'b01010,
        CMD_SHUT       = 5'b01011,
        CMD_DESYNC     = 5'b01101,
        CMD_WARM       = 5'b01111,
        CMD_RB_CRC     = 5'b10000,
        CMD_WDOG       = 5'b10001,
        CMD_REREAD     = 5'b10010,
        CMD_NEG_EDGE   = 5'b10011
    } cmd_code_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_IDLE  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_MULTI = 2'd2,
        MODE_READ  = 2'd3
    } mode_e;

    // One flag per executed command, all zero when nothing executes.
    typedef struct packed {
        logic write;
        logic multi;
        logic read;
        logic hold_rel;
        logic hold_set;
        logic start;
        logic ram_clr;
        logic crc_rst;
        logic clk_sw;
        logic ff_rest;
        logic shut;
        logic desync;
        logic warm;
        logic rb_crc;
        logic wdog;
        logic reread;
        logic neg_edge;
    } cmd_dec_t;

endpackage

// File: rtl/cfg_cmd_decode.sv
// Command decoder: turns the executing code into one flag per command.
// Assumes exec_i marks the cycle of execution; unlisted codes and the
// no-operation code yield an all-zero flag set.
module cfg_cmd_decode
    import cfg_cmd_pkg::*;
(
    input  logic             exec_i,
    input  logic [CMD_W-1:0] code_i,
    output cmd_dec_t         dec_o
);

    // Map the executing code onto its flag.
    always_comb begin
        dec_o = '0;
        if (exec_i) begin
            case (code_i)
                CMD_WRITE:    dec_o.write    = 1'b1;
                CMD_MULTI:    dec_o.multi    = 1'b1;
                CMD_READ:     dec_o.read     = 1'b1;
                CMD_HOLD_REL: dec_o.hold_rel = 1'b1;
                CMD_HOLD_SET: dec_o.hold_set = 1'b1;
                CMD_START:    dec_o.start    = 1'b1;
                CMD_RAM_CLR:  dec_o.ram_clr  = 1'b1;
                CMD_CRC_RST:  dec_o.crc_rst  = 1'b1;
                CMD_CLK_SW:   dec_o.clk_sw   = 1'b1;
                CMD_FF_REST:  dec_o.ff_rest  = 1'b1;
                CMD_SHUT:     dec_o.shut     = 1'b1;
                CMD_DESYNC:   dec_o.desync   = 1'b1;
                CMD_WARM:     dec_o.warm     = 1'b1;
                CMD_RB_CRC:   dec_o.rb_crc   = 1'b1;
                CMD_WDOG:     dec_o.wdog     = 1'b1;
                CMD_REREAD:   dec_o.reread   = 1'b1;
                CMD_NEG_EDGE: dec_o.neg_edge = 1'b1;
                default:      dec_o = '0;
            endcase
        end
    end

    // R11: nothing is flagged when no command executes
    always_comb begin
        if (!exec_i) begin
            a_idle_quiet_r11: assert ($countones(dec_o) == 0);
        end
    end

endmodule

// File: rtl/cfg_cmd_state.sv
// Sticky configuration state: data-path mode, interconnect hold with the
// readback-CRC recompute it causes, word alignment, capture edge, and the
// single-use flash re-read request.
// Assumes dec_i carries at most one flag per cycle.
module cfg_cmd_state
    import cfg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_dec_t          dec_i,
    input  logic              sync_found_i,
    input  logic              fallback_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              hold_n_o,
    output logic              rb_crc_o,
    output logic              aligned_o,
    output logic              neg_edge_o,
    output logic              reread_o
);

    logic mode_clr;
    logic reread_done;
    logic reread_fire;

    assign mode_clr = dec_i.hold_rel | dec_i.hold_set | dec_i.start |
                      dec_i.ram_clr  | dec_i.crc_rst  | dec_i.clk_sw |
                      dec_i.ff_rest  | dec_i.shut     | dec_i.desync |
                      dec_i.warm     | dec_i.rb_crc   | dec_i.wdog   |
                      dec_i.reread   | dec_i.neg_edge;

    assign reread_fire = dec_i.reread & ~reread_done & ~fallback_i;

    // Track the data-path mode selected by the last listed command.
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_o <= MODE_IDLE;
        else if (dec_i.write)    mode_o <= MODE_WRITE;
        else if (dec_i.multi)    mode_o <= MODE_MULTI;
        else if (dec_i.read)     mode_o <= MODE_READ;
        else if (mode_clr)       mode_o <= MODE_IDLE;
    end

    // Interconnect hold and the recompute pulse on its release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_n_o <= 1'b1;
            rb_crc_o <= 1'b0;
        end else begin
            rb_crc_o <= dec_i.rb_crc | (dec_i.hold_rel & ~hold_n_o);
            if (dec_i.hold_set)      hold_n_o <= 1'b0;
            else if (dec_i.hold_rel) hold_n_o <= 1'b1;
        end
    end

    // Alignment flag: desynchronise wins over a sync detection.
    always_ff @(posedge clk) begin
        if (!rst_n)            aligned_o <= 1'b0;
        else if (dec_i.desync) aligned_o <= 1'b0;
        else if (sync_found_i) aligned_o <= 1'b1;
    end

    // Capture edge select and single-use flash re-read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_edge_o  <= 1'b0;
            reread_o    <= 1'b0;
            reread_done <= 1'b0;
        end else begin
            if (dec_i.neg_edge) neg_edge_o <= 1'b1;
            reread_o <= reread_fire;
            if (reread_fire) reread_done <= 1'b1;
        end
    end

    // R4: hold only moves when a hold command executes
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_i.hold_set | dec_i.hold_rel) |=> $stable(hold_n_o));

    // R8: desynchronise leaves the alignment flag clear
    p_desync_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i.desync |=> !aligned_o);

    // R9: a re-read pulse never follows an earlier one
    p_reread_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reread_o |=> (!reread_o && reread_done));

    // R10: falling-edge select is sticky
    p_edge_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        neg_edge_o |=> neg_edge_o);

    // R3: mode only changes when a command executes
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(dec_i) == 0) |=> $stable(mode_o));

endmodule

// File: rtl/cfg_cmd_defer.sv
// Deferred start-up and shutdown requests. Start-up waits for both a CRC
// pass and a desynchronise command after arming; shutdown waits for a CRC
// pass or a CRC reset command after arming.
// Assumes crc_ok_i is a single-cycle pulse from the CRC engine.
module cfg_cmd_defer
    import cfg_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_dec_t dec_i,
    input  logic     crc_ok_i,
    output logic     start_pend_o,
    output logic     start_go_o,
    output logic     shut_pend_o,
    output logic     shut_go_o
);

    logic seen_crc;
    logic seen_desync;
    logic crc_now;
    logic desync_now;
    logic start_done;
    logic shut_done;

    assign crc_now    = seen_crc | crc_ok_i;
    assign desync_now = seen_desync | dec_i.desync;
    assign start_done = start_pend_o & ~dec_i.start & crc_now & desync_now;
    assign shut_done  = shut_pend_o & ~dec_i.shut & (crc_ok_i | dec_i.crc_rst);

    // Start-up request: arm, collect both events, then trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pend_o <= 1'b0;
            start_go_o   <= 1'b0;
            seen_crc     <= 1'b0;
            seen_desync  <= 1'b0;
        end else begin
            start_go_o <= start_done;
            if (dec_i.start) begin
                start_pend_o <= 1'b1;
                seen_crc     <= 1'b0;
                seen_desync  <= 1'b0;
            end else if (start_done) begin
                start_pend_o <= 1'b0;
                seen_crc     <= 1'b0;
                seen_desync  <= 1'b0;
            end else if (start_pend_o) begin
                seen_crc    <= crc_now;
                seen_desync <= desync_now;
            end
        end
    end

    // Shutdown request: arm, then trigger on the first qualifying event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shut_pend_o <= 1'b0;
            shut_go_o   <= 1'b0;
        end else begin
            shut_go_o <= shut_done;
            if (dec_i.shut)     shut_pend_o <= 1'b1;
            else if (shut_done) shut_pend_o <= 1'b0;
        end
    end

    // R6: a start-up trigger needs an armed request
    p_start_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_go_o |-> ($past(start_pend_o) && !start_pend_o));

    // R7: a shutdown trigger needs an armed request
    p_shut_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shut_go_o |-> ($past(shut_pend_o) && !shut_pend_o));

    // R6: start-up cannot fire without a CRC pass in that cycle or earlier
    p_start_needs_crc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pend_o && !seen_crc && !crc_ok_i) |=> !start_go_o);

endmodule

// File: rtl/cfg_cmd_seq.sv
// Configuration command sequencer top: holds the command, executes it on
// every write and every frame-address reload, and registers the strobes.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module cfg_cmd_seq
    import cfg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              far_load,
    input  logic              crc_ok,
    input  logic              sync_found,
    input  logic              fallback,
    input  logic              cfg_word_valid,
    output logic              cfg_word_accept,
    output logic [CMD_W-1:0]  cmd_q_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              crc_rst_o,
    output logic              ff_restore_o,
    output logic              wdog_reload_o,
    output logic              warm_boot_o,
    output logic              ram_clear_o,
    output logic              clk_switch_o,
    output logic              rb_crc_o,
    output logic              flash_reread_o,
    output logic              ic_hold_n_o,
    output logic              aligned_o,
    output logic              neg_edge_o,
    output logic              startup_pend_o,
    output logic              startup_go_o,
    output logic              shutdown_pend_o,
    output logic              shutdown_go_o
);

    localparam int NPULSE = 6;

    logic             exec;
    logic [CMD_W-1:0] exec_code;
    cmd_dec_t         dec;
    logic [NPULSE-1:0] pulse_d;
    logic [NPULSE-1:0] pulse_q;

    assign exec      = cmd_we | far_load;
    assign exec_code = cmd_we ? cmd_wdata : cmd_q_o;

    // Hold the last written command code.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q_o <= CMD_NOP;
        else if (cmd_we) cmd_q_o <= cmd_wdata;
    end

    cfg_cmd_decode u_dec (
        .exec_i (exec),
        .code_i (exec_code),
        .dec_o  (dec)
    );

    assign pulse_d = {dec.clk_sw, dec.ram_clr, dec.warm,
                      dec.wdog,   dec.ff_rest, dec.crc_rst};

    // Register the single-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    assign crc_rst_o     = pulse_q[0];
    assign ff_restore_o  = pulse_q[1];
    assign wdog_reload_o = pulse_q[2];
    assign warm_boot_o   = pulse_q[3];
    assign ram_clear_o   = pulse_q[4];
    assign clk_switch_o  = pulse_q[5];

    cfg_cmd_state u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec_i        (dec),
        .sync_found_i (sync_found),
        .fallback_i   (fallback),
        .mode_o       (mode_o),
        .hold_n_o     (ic_hold_n_o),
        .rb_crc_o     (rb_crc_o),
        .aligned_o    (aligned_o),
        .neg_edge_o   (neg_edge_o),
        .reread_o     (flash_reread_o)
    );

    cfg_cmd_defer u_defer (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec_i        (dec),
        .crc_ok_i     (crc_ok),
        .start_pend_o (startup_pend_o),
        .start_go_o   (startup_go_o),
        .shut_pend_o  (shutdown_pend_o),
        .shut_go_o    (shutdown_go_o)
    );

    assign cfg_word_accept = cfg_word_valid & aligned_o;

    // R1: a write lands in the held command one edge later
    p_cmd_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (cmd_q_o == $past(cmd_wdata)));

    // R1: without a write the held command is stable
    p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(cmd_q_o));

    // R2: at most one command strobe per cycle
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pulse_q, rb_crc_o, flash_reread_o}));

    // R2: no strobe follows a cycle without execution
    p_no_exec_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> (pulse_q == '0 && !rb_crc_o && !flash_reread_o));

endmodule

// File: tb/cfg_cmd_seq_test.sv
// Self-checking bench: directed sequences then seeded random traffic, each
// cycle compared with a behavioural model of the command semantics.
module cfg_cmd_seq_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_we, far_load, crc_ok, sync_found, fallback, cfg_word_valid;
    logic [4:0] cmd_wdata;
    logic       cfg_word_accept;
    logic [4:0] cmd_q_o;
    logic [1:0] mode_o;
    logic crc_rst_o, ff_restore_o, wdog_reload_o, warm_boot_o, ram_clear_o;
    logic clk_switch_o, rb_crc_o, flash_reread_o, ic_hold_n_o, aligned_o;
    logic neg_edge_o, startup_pend_o, startup_go_o, shutdown_pend_o, shutdown_go_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // model state
    logic [4:0] m_cmd;
    logic [1:0] m_mode;
    logic m_hold_n, m_al, m_neg, m_done, m_sp, m_sc, m_sd, m_hp;
    logic e_crc, e_ff, e_wd, e_warm, e_ram, e_clk, e_rb, e_rr, e_sgo, e_hgo;

    always #10 clk = ~clk;

    cfg_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .far_load(far_load), .crc_ok(crc_ok), .sync_found(sync_found),
        .fallback(fallback), .cfg_word_valid(cfg_word_valid),
        .cfg_word_accept(cfg_word_accept), .cmd_q_o(cmd_q_o), .mode_o(mode_o),
        .crc_rst_o(crc_rst_o), .ff_restore_o(ff_restore_o),
        .wdog_reload_o(wdog_reload_o), .warm_boot_o(warm_boot_o),
        .ram_clear_o(ram_clear_o), .clk_switch_o(clk_switch_o),
        .rb_crc_o(rb_crc_o), .flash_reread_o(flash_reread_o),
        .ic_hold_n_o(ic_hold_n_o), .aligned_o(aligned_o),
        .neg_edge_o(neg_edge_o), .startup_pend_o(startup_pend_o),
        .startup_go_o(startup_go_o), .shutdown_pend_o(shutdown_pend_o),
        .shutdown_go_o(shutdown_go_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_listed_clear(input logic [4:0] c);
        return (c == 5'd3) || (c >= 5'd5 && c <= 5'd11) || (c == 5'd13) ||
               (c == 5'd15) || (c >= 5'd16 && c <= 5'd19);
    endfunction

    task automatic model_reset();
        m_cmd = 0; m_mode = 0; m_hold_n = 1; m_al = 0; m_neg = 0; m_done = 0;
        m_sp = 0; m_sc = 0; m_sd = 0; m_hp = 0;
        {e_crc, e_ff, e_wd, e_warm, e_ram, e_clk, e_rb, e_rr, e_sgo, e_hgo} = '0;
    endtask

    // Advance the model by one clock edge using the driven inputs.
    task automatic model_edge();
        logic ex;
        logic [4:0] c;
        ex = cmd_we | far_load;
        c  = cmd_we ? cmd_wdata : m_cmd;
        {e_crc, e_ff, e_wd, e_warm, e_ram, e_clk, e_rb, e_rr, e_sgo, e_hgo} = '0;
        if (ex) begin
            case (c)
                5'd7:  e_crc  = 1;
                5'd10: e_ff   = 1;
                5'd17: e_wd   = 1;
                5'd15: e_warm = 1;
                5'd6:  e_ram  = 1;
                5'd9:  e_clk  = 1;
                5'd16: e_rb   = 1;
                5'd3:  e_rb   = !m_hold_n;
                default: ;
            endcase
            if (c == 5'd1) m_mode = 1;
            else if (c == 5'd2) m_mode = 2;
            else if (c == 5'd4) m_mode = 3;
            else if (is_listed_clear(c)) m_mode = 0;
            if (c == 5'd8) m_hold_n = 0;
            if (c == 5'd3) m_hold_n = 1;
            if (c == 5'd19) m_neg = 1;
            if (c == 5'd18 && !m_done && !fallback) begin e_rr = 1; m_done = 1; end
        end
        if (ex && c == 5'd13) m_al = 0;
        else if (sync_found) m_al = 1;
        if (ex && c == 5'd5) begin
            m_sp = 1; m_sc = 0; m_sd = 0;
        end else if (m_sp) begin
            if (crc_ok) m_sc = 1;
            if (ex && c == 5'd13) m_sd = 1;
            if (m_sc && m_sd) begin e_sgo = 1; m_sp = 0; m_sc = 0; m_sd = 0; end
        end
        if (ex && c == 5'd11) m_hp = 1;
        else if (m_hp && (crc_ok || (ex && c == 5'd7))) begin e_hgo = 1; m_hp = 0; end
        if (cmd_we) m_cmd = cmd_wdata;
    endtask

    task automatic compare_all();
        chk("R1 cmd_q", cmd_q_o, m_cmd);
        chk("R3 mode", mode_o, m_mode);
        chk("R2 crc_rst", crc_rst_o, e_crc);
        chk("R2 ff_restore", ff_restore_o, e_ff);
        chk("R2 wdog_reload", wdog_reload_o, e_wd);
        chk("R2 warm_boot", warm_boot_o, e_warm);
        chk("R2 ram_clear", ram_clear_o, e_ram);
        chk("R2 clk_switch", clk_switch_o, e_clk);
        chk("R5 rb_crc", rb_crc_o, e_rb);
        chk("R9 flash_reread", flash_reread_o, e_rr);
        chk("R4 ic_hold_n", ic_hold_n_o, m_hold_n);
        chk("R8 aligned", aligned_o, m_al);
        chk("R10 neg_edge", neg_edge_o, m_neg);
        chk("R6 startup_pend", startup_pend_o, m_sp);
        chk("R6 startup_go", startup_go_o, e_sgo);
        chk("R7 shutdown_pend", shutdown_pend_o, m_hp);
        chk("R7 shutdown_go", shutdown_go_o, e_hgo);
    endtask

    // Drive one cycle of inputs at the falling edge and check after the next.
    task automatic cyc(input logic we, input logic [4:0] wd, input logic far,
                       input logic crc, input logic sy, input logic fb,
                       input logic vld);
        cmd_we = we; cmd_wdata = wd; far_load = far; crc_ok = crc;
        sync_found = sy; fallback = fb; cfg_word_valid = vld;
        #1;
        chk("R8 word_accept", cfg_word_accept, vld & m_al);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [4:0] c);
        cyc(1, c, 0, 0, 0, fallback, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, fallback, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        cmd_we = 0; cmd_wdata = 0; far_load = 0; crc_ok = 0;
        sync_found = 0; fallback = 0; cfg_word_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        // R12: reset state
        do_reset();
        chk("R12 hold_n after reset", ic_hold_n_o, 1);
        chk("R12 mode after reset", mode_o, 0);

        // R2: strobes and re-execution on frame address reload
        wr(5'd7); wr(5'd10); wr(5'd17); wr(5'd15); wr(5'd6); wr(5'd9);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R2 reload re-executes clock switch", clk_switch_o, 1);
        // R3: modes
        wr(5'd1); cyc(0, 0, 1, 0, 0, 0, 0); wr(5'd2); wr(5'd4);
        chk("R3 read mode", mode_o, 3);
        // R11: unlisted codes change nothing
        wr(5'd12); wr(5'd14); wr(5'd20); wr(5'd31); wr(5'd0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R11 mode held over unlisted", mode_o, 3);
        // R4/R5: hold toggle and recompute
        wr(5'd8); idle(2); wr(5'd3);
        chk("R5 recompute on release", rb_crc_o, 1);
        wr(5'd3);
        chk("R5 no recompute when not held", rb_crc_o, 0);
        wr(5'd16);
        // R8: alignment and word ignore
        cyc(0, 0, 0, 0, 1, 0, 1); cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(1, 5'd13, 0, 0, 1, 0, 1); cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R8 desync clears alignment", aligned_o, 0);
        // R6: start-up, events in both orders
        wr(5'd5); cyc(0, 0, 0, 1, 0, 0, 0); idle(1); wr(5'd13);
        chk("R6 startup fires", startup_go_o, 1);
        wr(5'd5); wr(5'd13); cyc(0, 0, 1, 0, 0, 0, 0); cyc(0, 0, 0, 1, 0, 0, 0);
        // R6: reload re-arms and discards events
        wr(5'd5); cyc(0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 1, 0, 0, 0, 0);
        wr(5'd13); chk("R6 re-armed waits for CRC", startup_pend_o, 1);
        cyc(0, 0, 0, 1, 0, 0, 0);
        // R7: shutdown via CRC reset command and via CRC pass
        wr(5'd11); wr(5'd7);
        chk("R7 shutdown via crc reset", shutdown_go_o, 1);
        wr(5'd11); cyc(0, 0, 0, 1, 0, 0, 0);
        // R9: fallback suppresses, then once only
        fallback = 1; wr(5'd18);
        chk("R9 suppressed by fallback", flash_reread_o, 0);
        fallback = 0; wr(5'd18);
        chk("R9 first reread", flash_reread_o, 1);
        wr(5'd18); cyc(0, 0, 1, 0, 0, 0, 0);
        // R10: capture edge sticky
        wr(5'd19); wr(5'd0); idle(2);
        chk("R10 edge sticky", neg_edge_o, 1);

        // Random traffic
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            logic [4:0] c;
            logic we, far, crc, sy, fb, vld;
            c   = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 20);
            we  = ($urandom % 10) < 3;
            far = ($urandom % 10) < 2;
            crc = ($urandom % 10) == 0;
            sy  = ($urandom % 10) == 0;
            fb  = ($urandom % 50) == 0 ? ~fallback : fallback;
            vld = $urandom % 2;
            cyc(we, c, far, crc, sy, fb, vld);
            if (i == 3000) do_reset();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule